// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a calendar clock held entirely in packed BCD. It counts seconds, minutes, hours (24-hour), day of month, month and a two-digit year standing for 2000 to 2099, plus a free-running weekday. A one-second step comes from dividing a 32768 Hz clock-enable input (`tick_32k`) that is sampled on the fast system clock. The divider ratio is the parameter `TICKS_PER_SEC`, which must be at least 2. The month length follows the calendar: February has 29 days in years whose value is a multiple of four.

Software reaches the block through a byte-wide register port with an address, write data, a write strobe and a combinational read. The port has no back-pressure. A write is accepted on every clock edge where `bus_we` is high, and `bus_rdata` always shows the register that `bus_addr` selects. The port carries only single register accesses, so it uses plain strobes and no valid/ready handshake.

An alarm compares all six date and time fields against the running time, with no field excluded. A status register reports power-up, the alarm, the rollovers from the most recent step, the run state and a busy flag. The busy flag warns that a step is about to happen. Two interrupt outputs are gated by enable bits.

Top module: `bcdrtc_core`

## Requirements
- R1: After reset the time registers read sec 0x00 (offset 0x00), min 0x00 (0x04), hour 0x00 (0x08), day 0x01 (0x0C), month 0x01 (0x10) and year 0x00 (0x14). The weekday at 0x18 reads 0x00, control at 0x40 reads 0x00 (stopped), status at 0x44 reads 0x80 and interrupt enable at 0x48 reads 0x00.
- R2: Control bit 0 set to 1 runs the clock. While it runs, every `TICKS_PER_SEC`-th high sample of `tick_32k` advances the time by one second. Status bit 1 reads as control bit 0.
- R3: Seconds and minutes step in BCD and wrap from 0x59 to 0x00 with a carry. Hours wrap from 0x23 to 0x00 with a carry into the day.
- R4: The day wraps to 0x01 after the last day of the month, with a carry into the month. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for the other months except February. February ends on 0x29 when the year is a multiple of four and on 0x28 otherwise. The month wraps from 0x12 to 0x01 with a carry into the year, and the year wraps from 0x99 to 0x00.
- R5: The weekday at 0x18 counts 0 to 6. It advances modulo 7 on every day carry.
- R6: Status bit 0 (busy) is 1 exactly while the clock runs and the divider sits in the last tick period before a step. In every other case it is 0, so it drops on the cycle that follows each step.
- R7: Each step loads the event bits of the status register: bit 2 is set to 1, bit 3 records a minute carry, bit 4 an hour carry and bit 5 a day carry. The bits hold until the next step, and writes to the status register do not change them.
- R8: The alarm fields sit at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34 and hold seconds through year. On the cycle after a step, the alarm flag (status bit 6) is set if all six fields equal the newly stepped time. A difference in any single field, the year included, leaves the flag clear.
- R9: Writing a 1 to status bit 7 or bit 6 clears that bit, and writing a 0 leaves it unchanged. If an alarm set and a clear fall on the same edge, the set wins.
- R10: `irq_timer` is high for exactly one cycle after each step when interrupt enable bit 2 is 1. `irq_alarm` is high while status bit 6 is 1 and interrupt enable bit 3 is 1.
- R11: A write takes effect at the clock edge on which `bus_we` is high. Control reads back all 8 bits. Interrupt enable reads back only bits 3 and 2, with the other bits at 0. Unmapped addresses (for example 0x1C and 0x3C) read 0x00.
- R12: While the clock is stopped, a write replaces the time field it addresses, and the time does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | 32768 Hz clock enable, one cycle per period |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_timer | output | 1 | One-second interrupt pulse |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The range assertions on the seconds and month registers assume that software writes only legal BCD values and real calendar dates. The hour-wrap and hold assertions assume that no time write falls on a step edge, which the busy window is there to prevent. The stimulus writes the time fields only while the clock is stopped and uses only valid dates, whereas alarm, control and status writes can arrive at any moment. The divider ratio stays at 8 with a `tick_32k` pattern that varies, which satisfies the assumption that `TICKS_PER_SEC` is at least 2 and on which the one-cycle timer pulse and the busy-drop check depend.

// File: rtl/bcdrtc_pkg.sv
package bcdrtc_pkg;

  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_STAT = 8'h44;
  localparam logic [7:0] ADDR_IEN  = 8'h48;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } stamp_t;

  // one BCD increment of a two-digit value (caller handles the wrap)
  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last day of a month, in BCD; a BCD year is a multiple of four when
  // an even tens digit pairs with 0/4/8 or an odd tens digit with 2/6
  function automatic logic [7:0] bcd_month_end(input logic [7:0] mon,
                                                input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcdrtc_tick_gen.sv
module bcdrtc_tick_gen #(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic sec_step,
  output logic busy
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           phase <= '0;
    else if (run && tick) phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  // the last tick period before a step is the unsafe window
  assign busy     = run && (phase == LAST);
  assign sec_step = busy && tick;

  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> !busy); // R6

endmodule

// File: rtl/bcdrtc_calendar.sv
module bcdrtc_calendar
  import bcdrtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       wr_en,
  input  logic [2:0] wr_fld,
  input  logic [7:0] wr_val,
  output stamp_t     now,
  output logic [2:0] wday,
  output logic [3:0] events
);
  stamp_t     nxt;
  logic [2:0] nxt_wday;
  logic       c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    nxt      = now;
    nxt_wday = wday;
    c_min    = (now.sec == 8'h59);
    c_hr     = c_min && (now.min == 8'h59);
    c_day    = c_hr  && (now.hr == 8'h23);
    c_mon    = c_day && (now.day == bcd_month_end(now.mon, now.yr));
    c_yr     = c_mon && (now.mon == 8'h12);
    nxt.sec  = c_min ? 8'h00 : bcd_next(now.sec);
    if (c_min) nxt.min = c_hr ? 8'h00 : bcd_next(now.min);
    if (c_hr)  nxt.hr  = c_day ? 8'h00 : bcd_next(now.hr);
    if (c_day) begin
      nxt.day  = c_mon ? 8'h01 : bcd_next(now.day);
      nxt_wday = (wday == 3'd6) ? 3'd0 : wday + 3'd1;
    end
    if (c_mon) nxt.mon = c_yr ? 8'h01 : bcd_next(now.mon);
    if (c_yr)  nxt.yr  = (now.yr == 8'h99) ? 8'h00 : bcd_next(now.yr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now    <= '{yr: 8'h00, mon: 8'h01, day: 8'h01, hr: 8'h00, min: 8'h00, sec: 8'h00};
      wday   <= 3'd0;
      events <= 4'd0;
    end else begin
      if (step) begin
        now    <= nxt;
        wday   <= nxt_wday;
        events <= {c_day, c_hr, c_min, 1'b1};
      end
      if (wr_en) begin  // a write wins over the step for its own field
        case (wr_fld)
          3'd0: now.sec <= wr_val;
          3'd1: now.min <= wr_val;
          3'd2: now.hr  <= wr_val;
          3'd3: now.day <= wr_val;
          3'd4: now.mon <= wr_val;
          3'd5: now.yr  <= wr_val;
          3'd6: wday    <= wr_val[2:0];
          default: ;
        endcase
      end
    end
  end

  AST_SEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    now.sec[3:0] <= 4'd9 && now.sec <= 8'h59); // R3
  AST_MON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    now.mon >= 8'h01 && now.mon <= 8'h12); // R4
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_en && now.hr == 8'h23 && now.min == 8'h59 && now.sec == 8'h59
    |=> now.hr == 8'h00 && now.min == 8'h00); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !wr_en |=> $stable(now) && $stable(wday)); // R12

endmodule

// File: rtl/bcdrtc_alarm_match.sv
module bcdrtc_alarm_match
  import bcdrtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_fld,
  input  logic [7:0] wr_val,
  input  stamp_t     now,
  output stamp_t     target,
  output logic       hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) target <= '0;
    else if (wr_en) begin
      case (wr_fld)
        3'd0: target.sec <= wr_val;
        3'd1: target.min <= wr_val;
        3'd2: target.hr  <= wr_val;
        3'd3: target.day <= wr_val;
        3'd4: target.mon <= wr_val;
        3'd5: target.yr  <= wr_val;
        default: ;
      endcase
    end
  end

  // every field takes part; none can be excluded
  assign hit = (target == now);

endmodule

// File: rtl/bcdrtc_core.sv
module bcdrtc_core
  import bcdrtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_we,
  output logic [7:0] bus_rdata,
  output logic       irq_timer,
  output logic       irq_alarm
);
  logic [2:0] slot;
  logic       aligned, hit_time, hit_alarm, stat_we;
  logic       sec_step, busy, step_d, alarm_hit;
  logic [7:0] ctrl_q;
  logic [1:0] ien_q;          // {alarm, timer}
  logic       pwrup_q, alarm_q;
  stamp_t     now, target;
  logic [2:0] wday;
  logic [3:0] events;

  assign slot      = bus_addr[4:2];
  assign aligned   = (bus_addr[1:0] == 2'd0);
  assign hit_time  = aligned && (bus_addr[7:5] == 3'd0) && (slot != 3'd7);
  assign hit_alarm = aligned && (bus_addr[7:5] == 3'd1) && (slot <= 3'd5);
  assign stat_we   = bus_we && (bus_addr == ADDR_STAT);

  bcdrtc_tick_gen #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[0]), .tick(tick_32k),
    .sec_step(sec_step), .busy(busy));

  bcdrtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(sec_step),
    .wr_en(bus_we && hit_time), .wr_fld(slot), .wr_val(bus_wdata),
    .now(now), .wday(wday), .events(events));

  bcdrtc_alarm_match u_alm (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we && hit_alarm), .wr_fld(slot), .wr_val(bus_wdata),
    .now(now), .target(target), .hit(alarm_hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h00;
      ien_q   <= 2'b00;
      pwrup_q <= 1'b1;
      alarm_q <= 1'b0;
      step_d  <= 1'b0;
    end else begin
      step_d <= sec_step;
      if (bus_we && bus_addr == ADDR_CTRL) ctrl_q <= bus_wdata;
      if (bus_we && bus_addr == ADDR_IEN)  ien_q  <= bus_wdata[3:2];
      if (stat_we && bus_wdata[7])         pwrup_q <= 1'b0;
      alarm_q <= (step_d && alarm_hit) || (alarm_q && !(stat_we && bus_wdata[6]));
    end
  end

  assign irq_timer = step_d && ien_q[0];
  assign irq_alarm = alarm_q && ien_q[1];

  always_comb begin
    bus_rdata = 8'h00;
    if (hit_time) begin
      case (slot)
        3'd0: bus_rdata = now.sec;
        3'd1: bus_rdata = now.min;
        3'd2: bus_rdata = now.hr;
        3'd3: bus_rdata = now.day;
        3'd4: bus_rdata = now.mon;
        3'd5: bus_rdata = now.yr;
        default: bus_rdata = {5'd0, wday};
      endcase
    end else if (hit_alarm) begin
      case (slot)
        3'd0: bus_rdata = target.sec;
        3'd1: bus_rdata = target.min;
        3'd2: bus_rdata = target.hr;
        3'd3: bus_rdata = target.day;
        3'd4: bus_rdata = target.mon;
        default: bus_rdata = target.yr;
      endcase
    end else if (bus_addr == ADDR_CTRL) bus_rdata = ctrl_q;
    else if (bus_addr == ADDR_STAT) bus_rdata = {pwrup_q, alarm_q, events, ctrl_q[0], busy};
    else if (bus_addr == ADDR_IEN)  bus_rdata = {4'd0, ien_q, 2'd0};
  end

  AST_ALARM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    step_d && alarm_hit |=> alarm_q); // R8
  AST_PWRUP_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we && bus_wdata[7] |=> !pwrup_q); // R9
  AST_TIMER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_timer |=> !irq_timer); // R10

endmodule

// File: tb/bcdrtc_core_tb_top.sv
module bcdrtc_core_tb_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_timer, irq_alarm;

  int n_cmp = 0, n_bad = 0, tick_mode = 1, tcount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcdrtc_core #(.TICKS_PER_SEC(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .irq_timer(irq_timer), .irq_alarm(irq_alarm));

  // ---------------- behavioural reference model ----------------
  int t[7];        // sec, min, hr, day, mon, yr, weekday (binary)
  int al[6];
  int m_cnt;
  bit m_upd, m_pwr, m_alf, pulse, aset;
  logic [3:0] m_ev;
  logic [7:0] m_ctrl, m_ie;

  function automatic int b2i(input logic [7:0] d);
    return int'(d[7:4]) * 10 + int'(d[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction
  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    t = '{0, 0, 0, 1, 1, 0, 0};
    al = '{0, 0, 0, 0, 0, 0};
    m_cnt = 0; m_upd = 0; m_pwr = 1; m_alf = 0; m_ev = 4'd0;
    m_ctrl = 8'h00; m_ie = 8'h00;
  endtask

  task automatic advance();
    m_ev = 4'b0001;
    t[0]++;
    if (t[0] == 60) begin
      t[0] = 0; m_ev[1] = 1; t[1]++;
      if (t[1] == 60) begin
        t[1] = 0; m_ev[2] = 1; t[2]++;
        if (t[2] == 24) begin
          t[2] = 0; m_ev[3] = 1; t[6] = (t[6] + 1) % 7; t[3]++;
          if (t[3] > dim(t[4], t[5])) begin
            t[3] = 1; t[4]++;
            if (t[4] == 13) begin t[4] = 1; t[5] = (t[5] + 1) % 100; end
          end
        end
      end
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      pulse = m_ctrl[0] && tick_32k && (m_cnt == DIV - 1);
      aset  = m_upd && al[0] == t[0] && al[1] == t[1] && al[2] == t[2] &&
              al[3] == t[3] && al[4] == t[4] && al[5] == t[5];
      if (m_ctrl[0] && tick_32k) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      if (pulse) advance();
      if (bus_we) begin
        if (bus_addr <= 8'h18 && bus_addr[1:0] == 2'd0) t[bus_addr[4:2]] = b2i(bus_wdata);
        else if (bus_addr >= 8'h20 && bus_addr <= 8'h34 && bus_addr[1:0] == 2'd0)
          al[bus_addr[4:2]] = b2i(bus_wdata);
        else if (bus_addr == 8'h40) m_ctrl = bus_wdata;
        else if (bus_addr == 8'h48) m_ie = bus_wdata & 8'h0C;
        else if (bus_addr == 8'h44 && bus_wdata[7]) m_pwr = 0;
      end
      m_alf = aset || (m_alf && !(bus_we && bus_addr == 8'h44 && bus_wdata[6]));
      m_upd = pulse;
    end
  end

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a[1:0] != 2'd0) return 8'h00;
    if (a <= 8'h18) return i2b(t[a[4:2]]);
    if (a >= 8'h20 && a <= 8'h34) return i2b(al[a[4:2]]);
    if (a == 8'h40) return m_ctrl;
    if (a == 8'h44) return {m_pwr, m_alf, m_ev, m_ctrl[0], m_ctrl[0] && (m_cnt == DIV - 1)};
    if (a == 8'h48) return m_ie;
    return 8'h00;
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (a <= 8'h14) return "R3";
    if (a == 8'h18) return "R5";
    if (a >= 8'h20 && a <= 8'h34) return "R8";
    if (a == 8'h44) return "R7";
    return "R11";
  endfunction

  // compare DUT against the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (bus_rdata !== exp_rd(bus_addr)) begin
        n_bad++;
        $display("FAIL %s rd addr=%h actual=%h expected=%h", tag_of(bus_addr), bus_addr, bus_rdata, exp_rd(bus_addr));
      end
      n_cmp++;
      if (irq_timer !== (m_upd && m_ie[2])) begin
        n_bad++;
        $display("FAIL R10 irq_timer actual=%b expected=%b", irq_timer, m_upd && m_ie[2]);
      end
      n_cmp++;
      if (irq_alarm !== (m_alf && m_ie[3])) begin
        n_bad++;
        $display("FAIL R10 irq_alarm actual=%b expected=%b", irq_alarm, m_alf && m_ie[3]);
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    forever begin
      @(posedge clk); #1;
      tcount++;
      tick_32k = (tick_mode == 0) ? 1'b1 : (tcount % 3 != 0);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic chk_mask(input logic [7:0] a, input logic [7:0] mask,
                          input logic [7:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    n_cmp++;
    if ((bus_rdata & mask) !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata & mask, exp);
    end
  endtask

  task automatic chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    chk_mask(a, 8'hFF, exp, tag);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dy,
                          input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
    wr(8'h40, 8'h00);
    wr(8'h14, yr); wr(8'h10, mo); wr(8'h0C, dy);
    wr(8'h08, hr); wr(8'h04, mi); wr(8'h00, se);
  endtask

  task automatic set_alarm(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dy,
                           input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se);
    wr(8'h34, yr); wr(8'h30, mo); wr(8'h2C, dy);
    wr(8'h28, hr); wr(8'h24, mi); wr(8'h20, se);
  endtask

  task automatic wait_timer(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int k;
      k = 0;
      do begin
        @(negedge clk); k++;
      end while (!irq_timer && k < 1000);
      if (!irq_timer) begin
        n_cmp++; n_bad++;
        $display("FAIL %s no timer pulse actual=0 expected=1", tag);
        return;
      end
      @(negedge clk);
      chk_bit(irq_timer, 1'b0, "R10 pulse width");
    end
  endtask

  // one second from the stopped state, then stop again
  task automatic one_second();
    wr(8'h48, 8'h04);
    wr(8'h40, 8'h01);
    wait_timer(1, "R2");
    wr(8'h40, 8'h00);
  endtask

  initial begin
    int cnt;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    chk(8'h00, 8'h00, "R1 sec");  chk(8'h04, 8'h00, "R1 min");
    chk(8'h08, 8'h00, "R1 hour"); chk(8'h0C, 8'h01, "R1 day");
    chk(8'h10, 8'h01, "R1 month"); chk(8'h14, 8'h00, "R1 year");
    chk(8'h18, 8'h00, "R1 weekday"); chk(8'h40, 8'h00, "R1 ctrl");
    chk(8'h44, 8'h80, "R1 status"); chk(8'h48, 8'h00, "R1 ien");

    // R9: write-one-to-clear on power-up bit
    wr(8'h44, 8'h00); chk(8'h44, 8'h80, "R9 zero write keeps");
    wr(8'h44, 8'h80); chk(8'h44, 8'h00, "R9 one write clears");

    // R11: readback and unmapped
    wr(8'h48, 8'hFF); chk(8'h48, 8'h0C, "R11 ien mask");
    wr(8'h48, 8'h00);
    wr(8'h40, 8'hA0); chk(8'h40, 8'hA0, "R11 ctrl readback");
    wr(8'h40, 8'h00);
    chk(8'h3C, 8'h00, "R11 unmapped 3C"); chk(8'h1C, 8'h00, "R11 unmapped 1C");

    // R12: stopped clock holds written value
    wr(8'h00, 8'h58);
    repeat (40) @(posedge clk);
    chk(8'h00, 8'h58, "R12 hold while stopped");

    // R2 / R6: run state and busy window (tick every cycle)
    tick_mode = 0;
    wr(8'h40, 8'h01);
    chk_mask(8'h44, 8'h02, 8'h02, "R2 run bit");
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (bus_rdata[0]) cnt++;
    end
    chk_bit(cnt == 8, 1'b1, "R6 busy cycles per 64");
    wr(8'h40, 8'h00);
    tick_mode = 1;

    // R4/R5/R7: non-leap February end
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    wr(8'h18, 8'h06);
    one_second();
    chk(8'h0C, 8'h01, "R4 day"); chk(8'h10, 8'h03, "R4 month");
    chk(8'h08, 8'h00, "R3 hour wrap"); chk(8'h18, 8'h00, "R5 weekday wrap");
    chk(8'h44, 8'h3C, "R7 all events");

    // R4: leap February
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    one_second();
    chk(8'h0C, 8'h29, "R4 leap day"); chk(8'h10, 8'h02, "R4 leap month");
    chk(8'h18, 8'h01, "R5 weekday step");

    // R4: century wrap
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    one_second();
    chk(8'h14, 8'h00, "R4 year wrap"); chk(8'h10, 8'h01, "R4 month wrap");
    chk(8'h0C, 8'h01, "R4 day wrap");

    // R4: 30-day month; R7 minute-only event
    set_time(8'h30, 8'h04, 8'h30, 8'h10, 8'h20, 8'h59);
    one_second();
    chk(8'h04, 8'h21, "R3 minute carry"); chk(8'h0C, 8'h30, "R4 no day change");
    chk(8'h44, 8'h0C, "R7 minute event");
    wr(8'h44, 8'h3C);
    chk(8'h44, 8'h0C, "R7 events ignore writes");
    set_time(8'h30, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    one_second();
    chk(8'h0C, 8'h01, "R4 april end"); chk(8'h10, 8'h05, "R4 may");

    // R8/R9/R10: alarm match
    set_time(8'h30, 8'h06, 8'h15, 8'h08, 8'h30, 8'h00);
    set_alarm(8'h30, 8'h06, 8'h15, 8'h08, 8'h30, 8'h02);
    wr(8'h48, 8'h0C);
    wr(8'h40, 8'h01);
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!irq_alarm && cnt < 1000);
    wr(8'h40, 8'h00);
    chk(8'h00, 8'h02, "R8 time at alarm");
    chk(8'h44, 8'h44, "R8 alarm flag");
    chk_bit(irq_alarm, 1'b1, "R10 alarm irq");
    wr(8'h44, 8'h00); chk(8'h44, 8'h44, "R9 zero keeps alarm");
    wr(8'h48, 8'h04); @(negedge clk);
    chk_bit(irq_alarm, 1'b0, "R10 alarm irq gated");
    wr(8'h44, 8'h40); chk(8'h44, 8'h04, "R9 alarm cleared");

    // R8: year mismatch never fires
    set_time(8'h30, 8'h06, 8'h15, 8'h08, 8'h30, 8'h00);
    set_alarm(8'h31, 8'h06, 8'h15, 8'h08, 8'h30, 8'h02);
    wr(8'h48, 8'h0C);
    wr(8'h40, 8'h01);
    wait_timer(4, "R10");
    wr(8'h40, 8'h00);
    chk_mask(8'h44, 8'h40, 8'h00, "R8 year mismatch");

    // R10: no timer pulses while disabled
    wr(8'h48, 8'h08);
    wr(8'h40, 8'h01);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (irq_timer) cnt++;
    end
    chk_bit(cnt == 0, 1'b1, "R10 timer disabled");
    wr(8'h40, 8'h00);
    repeat (4) @(posedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule